// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is a single 16-bit up-counting timer channel with two compare points. A control word picks the count source: the core clock itself, or one of two slower strobes (a real-time tick and an external tick) that reach the block already synchronised as one-cycle enables. The chosen source is divided by a prescaler whose ratio is a power of four. Each divided tick advances the counter by one. The counter runs toward a full compare value and then wraps, so the channel repeats on its own with a fixed period.

Two events are produced. One fires when the counter arrives at the full compare value and the other when it arrives at the half compare value. The half compare value also sets the duty cycle of a pulse-width output, and that output has a programmable polarity. Software loads the two compare values, the counter and the control word through single-cycle write strobes that share one data bus. It can stop the channel in two ways: by dropping the channel enable, or by raising a stop input that gates the clock.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, count_val is 0, full_hit and half_hit are low, and pwm_out is low. The control word resets to 0 and both compare values reset to 16'hFFFF.
- R2: The count source is chosen from control bits [2:0], and the lowest set bit wins. Bit 0 counts every clock. Bit 1 counts on rtc_stb. Bit 2 counts on ext_stb. When all three bits are 0, the counter does not advance.
- R3: Control bits [5:3] set the prescale ratio. Codes 0, 1, 2, 3, 4 and 5 divide the source by 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 also divide by 1024.
- R4: Each prescaled tick raises the counter by one. A tick that arrives while the counter equals the full compare value loads 0 instead. A counter above the full compare value counts up through 16'hFFFF and wraps to 0.
- R5: full_hit is a one-cycle pulse. It is high in the first cycle after a tick that moves the counter to the full compare value, which is the cycle in which count_val first shows that value.
- R6: half_hit is a one-cycle pulse with the same timing as full_hit, but for the half compare value. If both compare values are equal, the two pulses fire together.
- R7: A counter write loads wr_data into the counter, and the new value shows on count_val in the next cycle. The write takes priority over a tick in the same cycle.
- R8: While chan_stop is high, the counter and the prescaler hold their values. While chan_en is low, the counter holds and the prescaler clears to 0.
- R9: Control bit 7 enables the pulse-width output, and control bit 8 inverts it. When enabled, the output is active while count_val is below the half compare value and inactive otherwise. When disabled, the output holds its inactive level, which equals control bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the first count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 16 | Shared write data for all registers |
| wr_full | input | 1 | Load the full compare value |
| wr_half | input | 1 | Load the half compare value |
| wr_cnt | input | 1 | Load the counter |
| wr_ctrl | input | 1 | Load the control word |
| chan_en | input | 1 | Channel enable |
| chan_stop | input | 1 | Clock gate; freezes the channel while high |
| rtc_stb | input | 1 | Real-time count strobe, already synchronised |
| ext_stb | input | 1 | External count strobe, already synchronised |
| full_hit | output | 1 | Pulse when the counter reaches the full compare value |
| half_hit | output | 1 | Pulse when the counter reaches the half compare value |
| count_val | output | 16 | Live counter value |
| pwm_out | output | 1 | Pulse-width output, polarity applied |

## Verification
The hardest case to reach is the slowest prescale ratio. The stimulus must hold the channel enabled for more than a thousand source strobes before a single tick appears, and it must also hit the prescale codes above 5 that share the longest ratio. Table rows with runs of over a thousand cycles and prescale codes 6 and 7 reach both. The bench counts the strobes it drives itself, so it can predict the tick count without knowing the prescaler phase. A second hard case is a counter write that lands in the same cycle as a tick. A directed test times the write to coincide with a divide-by-one tick and checks that the written value is not incremented.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int PRE_W = 10;

  typedef struct packed {
    logic       inv;
    logic       pwm_en;
    logic [2:0] presc;
    logic [2:0] src;
  } ctrl_t;

  // field positions of the control word
  function automatic ctrl_t ctrl_decode(input logic [15:0] w);
    ctrl_t c;
    c.src    = w[2:0];
    c.presc  = w[5:3];
    c.pwm_en = w[7];
    c.inv    = w[8];
    return c;
  endfunction

  // last prescaler phase for a ratio code (ratio minus one)
  function automatic logic [PRE_W-1:0] presc_last(input logic [2:0] code);
    logic [PRE_W-1:0] r;
    case (code)
      3'd0:    r = PRE_W'(0);
      3'd1:    r = PRE_W'(3);
      3'd2:    r = PRE_W'(15);
      3'd3:    r = PRE_W'(63);
      3'd4:    r = PRE_W'(255);
      default: r = PRE_W'(1023);
    endcase
    return r;
  endfunction

  // lowest set bit wins
  function automatic logic [2:0] src_grant(input logic [2:0] sel);
    return sel & (~sel + 3'd1);
  endfunction
endpackage

// File: rtl/ptc_src_sel.sv
module ptc_src_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       rtc_stb,
  input  logic       ext_stb,
  output logic       src_stb,
  output logic [2:0] grant
);
  import ptc_pkg::*;

  always_comb begin
    grant   = src_grant(sel);
    src_stb = (grant[0]) | (grant[1] & rtc_stb) | (grant[2] & ext_stb);
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((sel != 3'b000) -> (grant != 3'b000)));
endmodule

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
  parameter int PW = ptc_pkg::PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       chan_stop,
  input  logic       stb,
  input  logic [2:0] code,
  output logic       tick
);
  import ptc_pkg::*;

  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] last;
  logic          active;

  always_comb begin
    last   = presc_last(code);
    active = chan_en & ~chan_stop;
    tick   = active & stb & (pre_cnt >= last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (!chan_en)         pre_cnt <= '0;
    else if (tick)             pre_cnt <= '0;
    else if (active && stb)    pre_cnt <= pre_cnt + 1'b1;
  end

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && chan_stop) |=> $stable(pre_cnt));

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && chan_en) |=> (pre_cnt == '0));
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] full_val,
  input  logic [CW-1:0] half_val,
  output logic [CW-1:0] cnt,
  output logic          full_hit,
  output logic          half_hit
);
  logic [CW-1:0] step;
  logic          at_full;

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] c,
                                            input logic [CW-1:0] f);
    return (c == f) ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    at_full = (cnt == full_val);
    step    = advance(cnt, full_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      full_hit <= 1'b0;
      half_hit <= 1'b0;
    end else begin
      full_hit <= 1'b0;
      half_hit <= 1'b0;
      if (wr_cnt) begin
        cnt <= wr_data;
      end else if (tick) begin
        cnt      <= step;
        full_hit <= (step == full_val);
        half_hit <= (step == half_val);
      end
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && !at_full) |=> (cnt == $past(cnt) + 1'b1));

  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && at_full) |=> (cnt == '0));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(wr_data)));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt));

  // R5
  full_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_hit |-> ($past(tick) && !$past(wr_cnt)));

  // R6
  half_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_hit |-> ($past(tick) && !$past(wr_cnt)));
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] wr_data,
  input  logic          wr_full,
  input  logic          wr_half,
  input  logic          wr_cnt,
  input  logic          wr_ctrl,
  input  logic          chan_en,
  input  logic          chan_stop,
  input  logic          rtc_stb,
  input  logic          ext_stb,
  output logic          full_hit,
  output logic          half_hit,
  output logic [CW-1:0] count_val,
  output logic          pwm_out
);
  import ptc_pkg::*;

  logic [15:0]   ctrl_q;
  logic [CW-1:0] full_q;
  logic [CW-1:0] half_q;
  ctrl_t         cfg;
  logic          src_stb;
  logic [2:0]    grant;
  logic          tick;
  logic          pwm_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      full_q <= '1;
      half_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[15:0];
      if (wr_full) full_q <= wr_data;
      if (wr_half) half_q <= wr_data;
    end
  end

  assign cfg = ctrl_decode(ctrl_q);

  ptc_src_sel u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (cfg.src),
    .rtc_stb (rtc_stb),
    .ext_stb (ext_stb),
    .src_stb (src_stb),
    .grant   (grant)
  );

  ptc_prescaler #(.PW(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .chan_stop (chan_stop),
    .stb       (src_stb),
    .code      (cfg.presc),
    .tick      (tick)
  );

  ptc_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_cnt   (wr_cnt),
    .wr_data  (wr_data),
    .full_val (full_q),
    .half_val (half_q),
    .cnt      (count_val),
    .full_hit (full_hit),
    .half_hit (half_hit)
  );

  always_comb begin
    pwm_raw = cfg.pwm_en & (count_val < half_q);
    pwm_out = pwm_raw ^ cfg.inv;
  end

  // R9
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.pwm_en |-> (pwm_out == cfg.inv));

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_stop && !wr_cnt) |=> $stable(count_val));
endmodule

// File: tb/sim_pwm_timer_chan.sv
`timescale 1ns/1ps
module sim_pwm_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_full = 0, wr_half = 0, wr_cnt = 0, wr_ctrl = 0;
  logic        chan_en = 0, chan_stop = 0, rtc_stb = 0, ext_stb = 0;
  logic        full_hit, half_hit, pwm_out;
  logic [15:0] count_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_full(wr_full),
    .wr_half(wr_half), .wr_cnt(wr_cnt), .wr_ctrl(wr_ctrl),
    .chan_en(chan_en), .chan_stop(chan_stop), .rtc_stb(rtc_stb),
    .ext_stb(ext_stb), .full_hit(full_hit), .half_hit(half_hit),
    .count_val(count_val), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] full;
    logic [15:0] half;
    logic [15:0] ncyc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 16'd7,   16'd3, 16'd20},
    '{16'h0009, 16'd5,   16'd2, 16'd50},
    '{16'h0011, 16'd3,   16'd1, 16'd100},
    '{16'h0002, 16'd4,   16'd2, 16'd40},
    '{16'h000C, 16'd2,   16'd1, 16'd60},
    '{16'h0006, 16'd4,   16'd1, 16'd45},
    '{16'h0000, 16'd3,   16'd1, 16'd30},
    '{16'h0039, 16'd1,   16'd0, 16'd2100},
    '{16'h0019, 16'd100, 16'd5, 16'd700},
    '{16'h0021, 16'd1,   16'd1, 16'd1100},
    '{16'h0031, 16'd0,   16'd0, 16'd1030}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wreg(input int which, input logic [15:0] d);
    @(negedge clk);
    wr_data = d;
    wr_full = (which == 0);
    wr_half = (which == 1);
    wr_cnt  = (which == 2);
    wr_ctrl = (which == 3);
    @(negedge clk);
    wr_full = 0; wr_half = 0; wr_cnt = 0; wr_ctrl = 0;
  endtask

  function automatic int ratio(input logic [2:0] code);
    if (code >= 3'd5) return 1024;
    return 1 << (2 * code);
  endfunction

  // run enabled for n cycles, counting strobes of the chosen source and pulses
  task automatic run(input logic [15:0] ctrl, input int n,
                     output int strobes, output int nfull, output int nhalf);
    strobes = 0; nfull = 0; nhalf = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        nfull += full_hit;
        nhalf += half_hit;
      end
      chan_en = 1;
      rtc_stb = (i % 3 == 0);
      ext_stb = (i % 2 == 1);
      if (ctrl[0])      strobes++;
      else if (ctrl[1]) strobes += rtc_stb;
      else if (ctrl[2]) strobes += ext_stb;
    end
    @(negedge clk);
    nfull += full_hit;
    nhalf += half_hit;
    chan_en = 0; rtc_stb = 0; ext_stb = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s, nf, nh, ticks, ef, eh;
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count_val, 0);
    check("R1 full_hit", full_hit, 0);
    check("R1 half_hit", half_hit, 0);
    check("R1 pwm", pwm_out, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      wreg(3, VECS[v].ctrl);
      wreg(0, VECS[v].full);
      wreg(1, VECS[v].half);
      wreg(2, 16'd0);
      run(VECS[v].ctrl, int'(VECS[v].ncyc), s, nf, nh);
      ticks = s / ratio(VECS[v].ctrl[5:3]);
      ef = 0; eh = 0;
      for (int k = 1; k <= ticks; k++) begin
        if (k % (int'(VECS[v].full) + 1) == int'(VECS[v].full)) ef++;
        if (k % (int'(VECS[v].full) + 1) == int'(VECS[v].half)) eh++;
      end
      check($sformatf("R2/R3/R4 count vec%0d", v), count_val,
            ticks % (int'(VECS[v].full) + 1));
      check($sformatf("R5 full pulses vec%0d", v), nf, ef);
      check($sformatf("R6 half pulses vec%0d", v), nh, eh);
    end

    // R4 counter above full passes through FFFF to 0
    wreg(3, 16'h0001);
    wreg(0, 16'd3);
    wreg(2, 16'hFFFE);
    run(16'h0001, 3, s, nf, nh);
    check("R4 wrap past FFFF", count_val, 1);

    // R8 stop freezes the counter
    wreg(2, 16'd5);
    chan_stop = 1;
    run(16'h0001, 30, s, nf, nh);
    chan_stop = 0;
    check("R8 stop hold", count_val, 5);
    // R8 disabled channel holds
    repeat (10) @(negedge clk);
    check("R8 disabled hold", count_val, 5);

    // R7 write in the same cycle as a tick wins
    wreg(0, 16'hFFFF);
    wreg(2, 16'd0);
    @(negedge clk);
    chan_en = 1;
    @(negedge clk);
    @(negedge clk);
    wr_data = 16'h0100; wr_cnt = 1;
    @(negedge clk);
    wr_cnt = 0;
    check("R7 write over tick", count_val, 16'h0100);
    @(negedge clk);
    check("R7 count resumes", count_val, 16'h0101);
    chan_en = 0;

    // R9 pwm, normal and inverted
    for (int pol = 0; pol < 2; pol++) begin
      wreg(3, pol ? 16'h0181 : 16'h0081);
      wreg(0, 16'd9);
      wreg(1, 16'd4);
      wreg(2, 16'd0);
      @(negedge clk);
      chan_en = 1;
      for (int i = 0; i < 14; i++) begin
        @(negedge clk);
        c0 = count_val;
        check($sformatf("R9 pwm pol%0d cnt%0d", pol, c0), pwm_out,
              int'((c0 < 16'd4) ^ pol[0]));
      end
      chan_en = 0;
    end
    // R9 disabled output sits at inactive level
    wreg(3, 16'h0101);
    wreg(2, 16'd0);
    check("R9 disabled inv", pwm_out, 1);
    wreg(3, 16'h0001);
    check("R9 disabled", pwm_out, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule